// File: doc/BRIEF.md
# Resettable Sawtooth Ramp Counter

This block is a binary up-counter for a staircase sawtooth generator. A free-running high-frequency clock drives it. Its parallel count goes to an external resistor ladder, which turns the code into a stepped ramp. Each time the count rolls over from full scale to zero, the block raises a single-cycle pulse. The pulse can act as a sync or trigger for other circuits.

A separate restart input can arrive at any time, with no fixed relation to the clock. It is brought into the clock domain through a synchroniser. A rising edge on it forces the count back to zero and raises the same pulse as a natural rollover. By timing restart edges against the clock, a user can cut the ramp short and shape the waveform. A global initialisation puts the count at full scale. While the clock is still, the code stays at full scale.

Top module: `saw_ramp_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `code_out` becomes all ones (255 at the default width) and `wrap_pulse` becomes 0.
- R2: With no restart edge being applied, every rising edge of `clk_hf` raises `code_out` by exactly one, modulo 2^CNT_W.
- R3: A rollover from all ones to zero drives `wrap_pulse` high for exactly the one clock period in which `code_out` reads zero. With the restart input held still, this happens once every 2^CNT_W clock edges.
- R4: If `restart_in` is first sampled high at clock edge E, following a sampled low, then `code_out` reads 0 after edge E+2 and counts up again from the following edge.
- R5: The restart of R4 drives `wrap_pulse` high for the single clock period that follows edge E+2. A restart level held for only one sampled edge still counts as a rising edge.
- R6: If a restart clear and a natural rollover fall on the same edge, `code_out` ends at 0 and `wrap_pulse` is high for one period only.
- R7: A falling edge of `restart_in`, or a high level held on it, has no effect: counting continues as in R2 and no extra pulse appears.
- R8: While `clk_hf` stays low, `code_out` holds its value whatever `restart_in` does. After initialisation it rests at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hf | input | 1 | Free-running counting clock |
| rst_n | input | 1 | Synchronous active-low global initialisation |
| restart_in | input | 1 | Asynchronous ramp restart request, acts on its rising edge |
| code_out | output | CNT_W | Registered count for the external ladder |
| wrap_pulse | output | 1 | One-period pulse on rollover or restart |

## Verification
The bench builds the block with its default parameters: an 8-bit count and a two-stage synchroniser. At these values a full 256-edge ramp fits inside one run, so natural rollovers and restarts can be interleaved freely. With the three-edge restart latency fixed, the bench can place a restart on exactly the edge where the count reaches 255 and exercise the coincident case. Gating the bench clock shows that the count holds at full scale while the clock is still.

// File: rtl/saw_pkg.sv
// Package: shared constants and types for the sawtooth ramp counter.
// Assumes nothing beyond standard SystemVerilog packed types.
package saw_pkg;

    // Reason a rollover pulse is raised on a given edge.
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_WRAP    = 2'b01,
        CAUSE_RESTART = 2'b10,
        CAUSE_BOTH    = 2'b11
    } pulse_cause_e;

    // Minimum synchroniser depth accepted by the restart path.
    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/restart_edge_sync.sv
// Module: restart_edge_sync
// Brings an asynchronous restart level into the clock domain through a
// chain of SYNC_STAGES flops and flags its rising edge for one cycle.
// Assumes SYNC_STAGES >= 2. All flops clear on the synchronous active-low
// reset, so a level that is already high when reset ends counts as an edge.
module restart_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    import saw_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Synchroniser stages, one flop per stage.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_rest
                // Later stages pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[LAST];
    end

    // Rising edge of the synchronised level.
    always_comb rise_o = chain_q[LAST] & ~prev_q;

    // Elaboration check on the synchroniser depth.
    initial begin
        if (SYNC_STAGES < MIN_SYNC_STAGES)
            $error("restart_edge_sync: SYNC_STAGES below minimum");
    end

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("restart edge flag longer than one cycle"); // R5

endmodule

// File: rtl/ramp_counter.sv
// Module: ramp_counter
// Registered up-counter of CNT_W bits. It starts at all ones, steps by one on
// each clock edge, and clears to zero when clear_i is high at the edge.
// Flags when it sits at full scale so a rollover can be predicted.
// Assumes clear_i is synchronous to clk.
module ramp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [CNT_W-1:0] code_o,
    output logic             at_top_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] code_q;

    // Count register: init to full scale, clear or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= TOP;
        else if (clear_i) code_q <= '0;
        else              code_q <= code_q + ONE;
    end

    // Full-scale flag used to predict the rollover.
    always_comb at_top_o = (code_q == TOP);

    assign code_o = code_q;

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clear_i) |=> code_q == $past(code_q) + ONE)
        else $error("count did not step by one"); // R2

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clear_i) |=> code_q == '0)
        else $error("count not zero after clear"); // R4

endmodule

// File: rtl/wrap_pulse_gen.sv
// Module: wrap_pulse_gen
// Registers a single-cycle pulse on the edge where the counter either rolls
// over or is cleared by a restart. Both causes on the same edge give one pulse.
// Assumes both inputs are synchronous to clk.
module wrap_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic at_top_i,
    input  logic restart_i,
    output logic pulse_o
);
    import saw_pkg::*;

    pulse_cause_e cause;
    logic         pulse_q;

    // Classify the reason for a pulse on the coming edge.
    always_comb cause = pulse_cause_e'({restart_i, at_top_i});

    // Pulse register: high for one period after any cause.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (cause != CAUSE_NONE);
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/saw_ramp_gen.sv
// Module: saw_ramp_gen (top)
// Sawtooth ramp counter with a rollover pulse and an asynchronous restart.
// The restart is synchronised, its rising edge clears the count on the next
// edge and raises the rollover pulse. Assumes rst_n is synchronous to clk_hf.
module saw_ramp_gen #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_hf,
    input  logic             rst_n,
    input  logic             restart_in,
    output logic [CNT_W-1:0] code_out,
    output logic             wrap_pulse
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic restart_rise;
    logic at_top;

    restart_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_hf),
        .rst_n   (rst_n),
        .async_in(restart_in),
        .rise_o  (restart_rise)
    );

    ramp_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk_hf),
        .rst_n   (rst_n),
        .clear_i (restart_rise),
        .code_o  (code_out),
        .at_top_o(at_top)
    );

    wrap_pulse_gen u_pulse (
        .clk      (clk_hf),
        .rst_n    (rst_n),
        .at_top_i (at_top),
        .restart_i(restart_rise),
        .pulse_o  (wrap_pulse)
    );

    AST_PULSE_AT_ZERO: assert property (@(posedge clk_hf) disable iff (!rst_n)
        wrap_pulse |-> code_out == '0)
        else $error("pulse while count not zero"); // R3

    AST_ROLLOVER_PULSE: assert property (@(posedge clk_hf) disable iff (!rst_n)
        ($past(rst_n) && $past(code_out) == TOP) |-> (wrap_pulse && code_out == '0))
        else $error("rollover without pulse"); // R6

    AST_RESTART_PULSE: assert property (@(posedge clk_hf) disable iff (!rst_n)
        restart_rise |=> wrap_pulse)
        else $error("restart without pulse"); // R5

    AST_NO_STRAY_PULSE: assert property (@(posedge clk_hf) disable iff (!rst_n)
        (!restart_rise && code_out != TOP) |=> !wrap_pulse)
        else $error("pulse without cause"); // R7

endmodule

// File: tb/saw_ramp_gen_tb.sv
`timescale 1ns/1ps
module saw_ramp_gen_tb;
    localparam int W = 8;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Stimulus table: {restart level, number of clock edges to hold it}.
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {1'b0, 15'd300}, {1'b1, 15'd1},  {1'b0, 15'd12}, {1'b1, 15'd40},
        {1'b0, 15'd7},   {1'b1, 15'd3},  {1'b0, 15'd260}, {1'b1, 15'd2},
        {1'b0, 15'd5},   {1'b1, 15'd9}
    };

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic rst_n = 1'b0;
    logic restart_in = 1'b0;
    logic [W-1:0] code_out;
    logic wrap_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model state, built from the requirements.
    logic [W-1:0] m_code;
    logic m_pulse;
    logic h0, h1, h2;
    bit m_cleared;

    always #2.5 clk = clk_en ? ~clk : 1'b0;

    saw_ramp_gen #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk_hf(clk), .rst_n(rst_n), .restart_in(restart_in),
        .code_out(code_out), .wrap_pulse(wrap_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_code = TOP; m_pulse = 1'b0; h0 = 0; h1 = 0; h2 = 0; m_cleared = 0;
    endtask

    // One clock edge: update the model, then compare at the falling edge.
    task automatic step();
        logic r;
        @(posedge clk);
        r = h1 & ~h2;                 // restart seen high at E, low before: acts at E+2
        m_cleared = r;
        if (r) begin
            m_pulse = 1'b1; m_code = '0;
        end else begin
            m_pulse = (m_code == TOP); m_code = m_code + 1'b1;
        end
        h2 = h1; h1 = h0; h0 = restart_in;
        @(negedge clk);
        check(code_out == m_code, m_cleared ? "R4" : (restart_in ? "R7" : "R2"),
              code_out, m_code);
        check(wrap_pulse == m_pulse, m_cleared ? "R5" : "R3", wrap_pulse, m_pulse);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; restart_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        check(code_out == TOP, "R1 code", code_out, TOP);
        check(wrap_pulse == 1'b0, "R1 pulse", wrap_pulse, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int pulses;
        do_reset();

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            restart_in = VEC[v][15];
            for (int c = 0; c < int'(VEC[v][14:0]); c++) step();
        end

        // R6: restart clear lands on the edge where the count is at full scale.
        restart_in = 1'b0;
        for (int c = 0; c < 20; c++) step();
        while (m_code != TOP - 2) step();
        restart_in = 1'b1;
        step(); step();
        check(code_out == TOP, "R6 pre", code_out, TOP);
        step();
        check(code_out == 0 && wrap_pulse == 1'b1, "R6 clear", code_out, 0);
        pulses = 1;
        step();
        if (wrap_pulse) pulses++;
        check(pulses == 1, "R6 single pulse", pulses, 1);
        check(code_out == 1, "R6 resume", code_out, 1);

        // R7: falling edge and steady high have no effect.
        for (int c = 0; c < 5; c++) step();
        restart_in = 1'b0;
        for (int c = 0; c < 6; c++) step();

        // R8: clock held low, count rests at full scale.
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        clk_en = 1'b0;
        rst_n = 1'b1;
        #20 restart_in = 1'b1;
        #40 restart_in = 1'b0;
        #100;
        check(code_out == TOP, "R8 hold", code_out, TOP);
        check(wrap_pulse == 1'b0, "R8 pulse", wrap_pulse, 0);
        model_reset();
        clk_en = 1'b1;
        for (int c = 0; c < 4; c++) step();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule